// File: doc/BRIEF.md
# Byte-Window SPI Flash Bridge

This block gives a host bus a small register window through which it can talk to a SPI flash one byte at a time. Four address-byte registers hold a 32-bit target address. A fifth location, the data port, starts a cycle at that address. The page of the address decides what the cycle does. One page raises chip select. A second page lowers chip select and moves one byte over the serial link. A write sends the host's byte out. A read brings a byte back from the flash and returns it as the read data.

A host runs a flash transaction as a short series of accesses:
1. Load the address bytes.
2. Touch the deselect page once.
3. Switch to the transfer page and write the command bytes.
4. Read the response bytes.
5. Return to the deselect page.

The host holds each request until the block answers with a one-cycle ready pulse. For a serial byte, that pulse comes only after all eight clocks have run. The serialiser is built in and runs SPI mode 0 with a parameterised clock divider.

Top module: `spi_window_bridge`

## Requirements
- R1: After reset, and after any reset taken in the middle of a transfer:
  - `spi_cs_n` is 1, `spi_sck` is 0 and `host_ready` is 0.
  - All four address bytes read back as 0x00.
- R2: Window offsets 0, 1, 2 and 3 hold address bits [7:0], [15:8], [23:16] and [31:24]. A write stores the byte there. A read returns it.
- R3: A write of any value to the data port (offset 4), while the address lies in page 0xFFFFFExx, sets `spi_cs_n` to 1. It produces no SCK pulse.
- R4: A data-port write with the address in page 0xFFFFFDxx behaves as follows:
  - `spi_cs_n` goes to 0.
  - The write byte goes out on `spi_mosi`, most significant bit first, over exactly 8 SCK pulses in mode 0.
  - SCK idles low. MOSI never changes in a cycle where SCK rises.
- R5: A data-port read with the address in page 0xFFFFFDxx behaves as follows:
  - `spi_cs_n` goes to 0.
  - The block runs 8 SCK pulses with `spi_mosi` held at 0.
  - It samples `spi_miso` on each rising SCK edge, most significant bit first, and returns the byte on `host_rdata`.
- R6: Timing of `host_ready`:
  - It is a single-cycle pulse.
  - For a register access, or for a data-port access that moves no byte, it is high in the cycle after the accepting clock edge.
  - For a byte transfer, it is high 16*CLK_DIV+1 cycles after the accepting edge.
- R7: A data-port access outside the two decoded pages changes neither chip select nor SCK, and a read returns 0xFF. This includes a read of the deselect page. Offsets 5 to 7 are ignored in the same way.
- R8: Address bits [7:0] play no part in page decoding.
- R9: SCK never pulses while `spi_cs_n` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_req | input | 1 | Host access request, held until `host_ready` |
| host_wr | input | 1 | 1 for a write access, 0 for a read |
| host_ofs | input | 3 | Window offset: 0-3 address bytes, 4 data port |
| host_wdata | input | 8 | Write data |
| host_rdata | output | 8 | Read data, valid while `host_ready` is high |
| host_ready | output | 1 | One-cycle completion pulse |
| spi_cs_n | output | 1 | Flash chip select, active low |
| spi_sck | output | 1 | Serial clock, idle low |
| spi_mosi | output | 1 | Serial data to the flash |
| spi_miso | input | 1 | Serial data from the flash |

## Verification
The hardest state to reach from the ports is an ignored data-port access made while chip select is already low. Chip select is low only after a real transfer has run. The stimulus therefore performs a transfer-page write first. It then moves the address to an undecoded page and, later, to the deselect page for a read. It checks that chip select stays low, that no SCK pulse appears and that a read returns 0xFF. A reset is also forced partway through a byte, so that R1 is checked from a busy state and not only from power-up.

// File: rtl/spiw_pkg.sv
package spiw_pkg;
    localparam int BYTE_W = 8;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_XFER,
        ST_RESP
    } spiw_state_e;

    typedef enum logic [1:0] {
        PG_NONE,
        PG_DESEL,
        PG_XFER
    } spiw_page_e;

    typedef struct packed {
        spiw_state_e        state;
        logic               cs_n;
        logic               rd;
        logic [BYTE_W-1:0]  rdata;
    } spiw_ctl_t;
endpackage

// File: rtl/spiw_addr_regs.sv
module spiw_addr_regs #(
    parameter int NBYTES = 4,
    parameter int BW     = 8,
    localparam int IDXW  = (NBYTES > 1) ? $clog2(NBYTES) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [IDXW-1:0]      wr_idx,
    input  logic [BW-1:0]        wr_byte,
    input  logic [IDXW-1:0]      rd_idx,
    output logic [BW-1:0]        rd_byte,
    output logic [NBYTES*BW-1:0] addr
);
    logic [NBYTES-1:0][BW-1:0] regs_d, regs_q;

    always_comb begin
        regs_d = regs_q;
        if (wr_en) regs_d[wr_idx] = wr_byte;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) regs_q <= '0;
        else        regs_q <= regs_d;
    end

    assign rd_byte = regs_q[rd_idx];

    for (genvar g = 0; g < NBYTES; g++) begin : g_pack
        assign addr[g*BW +: BW] = regs_q[g];
    end
endmodule

// File: rtl/spiw_page_decode.sv
module spiw_page_decode
    import spiw_pkg::*;
#(
    parameter int          PW         = 24,
    parameter logic [PW-1:0] DESEL_PAGE = 24'hFFFFFE,
    parameter logic [PW-1:0] XFER_PAGE  = 24'hFFFFFD
) (
    input  logic [PW-1:0] page_bits,
    output spiw_page_e    page
);
    always_comb begin
        if (page_bits == DESEL_PAGE)     page = PG_DESEL;
        else if (page_bits == XFER_PAGE) page = PG_XFER;
        else                             page = PG_NONE;
    end
endmodule

// File: rtl/spiw_shifter.sv
module spiw_shifter #(
    parameter int CLK_DIV = 2,
    parameter int BW      = 8,
    localparam int DIVW   = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1,
    localparam int BITW   = $clog2(BW)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          rd_mode,
    input  logic [BW-1:0] tx_byte,
    input  logic          spi_miso,
    output logic          spi_sck,
    output logic          spi_mosi,
    output logic          done,
    output logic [BW-1:0] rx_byte
);
    localparam logic [DIVW-1:0] DIV_LAST = DIVW'(CLK_DIV - 1);
    localparam logic [BITW-1:0] BIT_LAST = BITW'(BW - 1);

    typedef struct packed {
        logic            busy;
        logic            sck;
        logic            rd;
        logic            done;
        logic [DIVW-1:0] div_cnt;
        logic [BITW-1:0] bit_cnt;
        logic [BW-1:0]   tx;
        logic [BW-1:0]   rx;
    } shf_t;

    shf_t d, q;

    always_comb begin
        d      = q;
        d.done = 1'b0;
        if (start && !q.busy) begin
            d.busy    = 1'b1;
            d.sck     = 1'b0;
            d.rd      = rd_mode;
            d.div_cnt = '0;
            d.bit_cnt = '0;
            d.tx      = rd_mode ? '0 : tx_byte;
        end else if (q.busy) begin
            if (q.div_cnt == DIV_LAST) begin
                d.div_cnt = '0;
                d.sck     = !q.sck;
                if (!q.sck) begin
                    d.rx = {q.rx[BW-2:0], spi_miso};
                end else if (q.bit_cnt == BIT_LAST) begin
                    d.busy = 1'b0;
                    d.done = 1'b1;
                end else begin
                    d.bit_cnt = q.bit_cnt + 1'b1;
                    d.tx      = {q.tx[BW-2:0], 1'b0};
                end
            end else begin
                d.div_cnt = q.div_cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign spi_sck  = q.sck;
    assign spi_mosi = q.tx[BW-1];
    assign done     = q.done;
    assign rx_byte  = q.rx;

    // R4: mode 0, data is steady across the rising SCK edge
    a_r4_mosi_steady_at_rise: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(spi_sck) |-> $stable(spi_mosi));
    // R5: a read cycle drives MOSI low throughout
    a_r5_read_mosi_low: assert property (@(posedge clk) disable iff (!rst_n)
        (q.busy && q.rd) |-> !spi_mosi);
    // R6: completion is a single pulse
    a_r6_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
endmodule

// File: rtl/spi_window_bridge.sv
module spi_window_bridge
    import spiw_pkg::*;
#(
    parameter int CLK_DIV = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        host_req,
    input  logic        host_wr,
    input  logic [2:0]  host_ofs,
    input  logic [7:0]  host_wdata,
    output logic [7:0]  host_rdata,
    output logic        host_ready,
    output logic        spi_cs_n,
    output logic        spi_sck,
    output logic        spi_mosi,
    input  logic        spi_miso
);
    localparam int NBYTES = 4;
    localparam int AW     = NBYTES * BYTE_W;
    localparam int PW     = AW - BYTE_W;
    localparam int IDXW   = $clog2(NBYTES);
    localparam int OFS_W  = 3;
    localparam logic [OFS_W-1:0] DATA_OFS = OFS_W'(NBYTES);

    spiw_ctl_t        d, q;
    logic             reg_we;
    logic [7:0]       reg_rd;
    logic [AW-1:0]    addr;
    spiw_page_e       page;
    logic             sh_start, sh_rd, sh_done;
    logic [7:0]       sh_rx;

    spiw_addr_regs #(.NBYTES(NBYTES), .BW(BYTE_W)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (reg_we),
        .wr_idx  (host_ofs[IDXW-1:0]),
        .wr_byte (host_wdata),
        .rd_idx  (host_ofs[IDXW-1:0]),
        .rd_byte (reg_rd),
        .addr    (addr)
    );

    spiw_page_decode #(.PW(PW)) u_dec (
        .page_bits (addr[AW-1:BYTE_W]),
        .page      (page)
    );

    spiw_shifter #(.CLK_DIV(CLK_DIV), .BW(BYTE_W)) u_shf (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (sh_start),
        .rd_mode  (sh_rd),
        .tx_byte  (host_wdata),
        .spi_miso (spi_miso),
        .spi_sck  (spi_sck),
        .spi_mosi (spi_mosi),
        .done     (sh_done),
        .rx_byte  (sh_rx)
    );

    always_comb begin
        d        = q;
        reg_we   = 1'b0;
        sh_start = 1'b0;
        sh_rd    = 1'b0;
        case (q.state)
            ST_IDLE: begin
                if (host_req) begin
                    d.state = ST_RESP;
                    d.rdata = 8'hFF;
                    if (host_ofs < DATA_OFS) begin
                        if (host_wr) reg_we  = 1'b1;
                        else         d.rdata = reg_rd;
                    end else if (host_ofs == DATA_OFS) begin
                        if (page == PG_DESEL && host_wr) begin
                            d.cs_n = 1'b1;
                        end else if (page == PG_XFER) begin
                            d.cs_n   = 1'b0;
                            d.rd     = !host_wr;
                            d.state  = ST_XFER;
                            sh_start = 1'b1;
                            sh_rd    = !host_wr;
                        end
                    end
                end
            end
            ST_XFER: begin
                if (sh_done) begin
                    d.state = ST_RESP;
                    d.rdata = q.rd ? sh_rx : 8'hFF;
                end
            end
            default: d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.state <= ST_IDLE;
            q.cs_n  <= 1'b1;
            q.rd    <= 1'b0;
            q.rdata <= 8'hFF;
        end else begin
            q <= d;
        end
    end

    assign host_ready = (q.state == ST_RESP);
    assign host_rdata = q.rdata;
    assign spi_cs_n   = q.cs_n;

    // R9: no serial clock while the flash is deselected
    a_r9_no_sck_deselected: assert property (@(posedge clk) disable iff (!rst_n)
        spi_cs_n |-> !spi_sck);
    // R6: ready is a one-cycle pulse
    a_r6_ready_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        host_ready |=> !host_ready);
    // R6: a finished byte is answered on the next cycle
    a_r6_ready_after_byte: assert property (@(posedge clk) disable iff (!rst_n)
        (q.state == ST_XFER && sh_done) |=> host_ready);
    // R7: chip select moves only on an accepted data-port access
    a_r7_cs_only_by_data_port: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(spi_cs_n) |-> $past(host_req && q.state == ST_IDLE && host_ofs == DATA_OFS));
endmodule

// File: tb/tb_spi_window_bridge.sv
`timescale 1ns/1ps
module tb_spi_window_bridge;
    localparam int DIV      = 2;
    localparam int XFER_LAT = 16 * DIV + 2;  // posedges incl. accepting edge (R6)

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       host_req = 1'b0, host_wr = 1'b0;
    logic [2:0] host_ofs = '0;
    logic [7:0] host_wdata = '0;
    logic [7:0] host_rdata;
    logic       host_ready, spi_cs_n, spi_sck, spi_mosi, spi_miso;

    int n_chk = 0, n_bad = 0;

    always #2.5 clk = ~clk;

    spi_window_bridge #(.CLK_DIV(DIV)) dut (
        .clk(clk), .rst_n(rst_n), .host_req(host_req), .host_wr(host_wr),
        .host_ofs(host_ofs), .host_wdata(host_wdata), .host_rdata(host_rdata),
        .host_ready(host_ready), .spi_cs_n(spi_cs_n), .spi_sck(spi_sck),
        .spi_mosi(spi_mosi), .spi_miso(spi_miso)
    );

    // flash model: capture MOSI on rise, present MISO MSB first, advance on fall
    logic [7:0] slave_byte = 8'h00;
    logic [7:0] mosi_cap   = 8'h00;
    logic [2:0] bitn       = 3'd0;
    int         pulses     = 0;
    always @(posedge spi_sck) begin
        mosi_cap <= {mosi_cap[6:0], spi_mosi};
        pulses   <= pulses + 1;
    end
    always @(negedge spi_sck) bitn <= bitn + 3'd1;
    assign spi_miso = slave_byte[3'd7 - bitn];

    task automatic check(input string req, input int act, input int exp, input string what);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic access(input logic [2:0] ofs, input logic wr, input logic [7:0] wd,
                          output logic [7:0] rd, output int cyc);
        @(negedge clk);
        host_req = 1'b1; host_wr = wr; host_ofs = ofs; host_wdata = wd;
        cyc = 0;
        forever begin
            @(posedge clk);
            cyc++;
            @(negedge clk);
            if (host_ready || cyc > 2000) break;
        end
        rd = host_rdata;
        host_req = 1'b0;
        @(negedge clk);
        check("R6", host_ready, 0, "ready pulse length");
    endtask

    typedef struct packed {
        logic [2:0] ofs;
        logic       wr;
        logic [7:0] wdata;
        logic [7:0] miso;
        logic [7:0] exp_rd;
        logic       exp_cs;
        logic [3:0] npul;
        logic [3:0] req;
    } vec_t;

    localparam int NV = 31;
    localparam vec_t VECS [NV] = '{
        '{3'd0,1'b1,8'h00,8'h00,8'h00,1'b1,4'd0,4'd2},  // R2 addr bytes
        '{3'd1,1'b1,8'hFE,8'h00,8'h00,1'b1,4'd0,4'd2},
        '{3'd2,1'b1,8'hFF,8'h00,8'h00,1'b1,4'd0,4'd2},
        '{3'd3,1'b1,8'hFF,8'h00,8'h00,1'b1,4'd0,4'd2},
        '{3'd1,1'b0,8'h00,8'h00,8'hFE,1'b1,4'd0,4'd2},  // R2 read back
        '{3'd3,1'b0,8'h00,8'h00,8'hFF,1'b1,4'd0,4'd2},
        '{3'd4,1'b1,8'h5A,8'h00,8'h00,1'b1,4'd0,4'd3},  // R3
        '{3'd1,1'b1,8'hFD,8'h00,8'h00,1'b1,4'd0,4'd2},
        '{3'd4,1'b1,8'h9F,8'h00,8'h00,1'b0,4'd8,4'd4},  // R4 command byte
        '{3'd4,1'b0,8'h00,8'hC2,8'hC2,1'b0,4'd8,4'd5},  // R5
        '{3'd4,1'b0,8'h00,8'h3D,8'h3D,1'b0,4'd8,4'd5},  // R5
        '{3'd0,1'b1,8'h77,8'h00,8'h00,1'b0,4'd0,4'd8},  // R8 low byte changes
        '{3'd4,1'b1,8'hA5,8'h00,8'h00,1'b0,4'd8,4'd8},  // R8 still decoded
        '{3'd1,1'b1,8'hFE,8'h00,8'h00,1'b0,4'd0,4'd2},
        '{3'd4,1'b1,8'h00,8'h00,8'h00,1'b1,4'd0,4'd3},  // R3 deselect after xfer
        '{3'd1,1'b1,8'hFC,8'h00,8'h00,1'b1,4'd0,4'd2},
        '{3'd4,1'b1,8'h11,8'h00,8'h00,1'b1,4'd0,4'd7},  // R7 unmapped write
        '{3'd4,1'b0,8'h00,8'h00,8'hFF,1'b1,4'd0,4'd7},  // R7 unmapped read
        '{3'd5,1'b0,8'h00,8'h00,8'hFF,1'b1,4'd0,4'd7},  // R7 offset 5
        '{3'd6,1'b1,8'h33,8'h00,8'h00,1'b1,4'd0,4'd7},  // R7 offset 6
        '{3'd0,1'b0,8'h00,8'h00,8'h77,1'b1,4'd0,4'd2},  // R2 untouched
        '{3'd1,1'b1,8'hFD,8'h00,8'h00,1'b1,4'd0,4'd2},
        '{3'd4,1'b1,8'h3C,8'h00,8'h00,1'b0,4'd8,4'd4},  // R4
        '{3'd1,1'b1,8'hFC,8'h00,8'h00,1'b0,4'd0,4'd2},
        '{3'd4,1'b1,8'hFF,8'h00,8'h00,1'b0,4'd0,4'd7},  // R7 cs held low
        '{3'd4,1'b0,8'h00,8'h00,8'hFF,1'b0,4'd0,4'd7},  // R7
        '{3'd1,1'b1,8'hFD,8'h00,8'h00,1'b0,4'd0,4'd2},
        '{3'd4,1'b0,8'h00,8'h81,8'h81,1'b0,4'd8,4'd5},  // R5
        '{3'd1,1'b1,8'hFE,8'h00,8'h00,1'b0,4'd0,4'd2},
        '{3'd4,1'b0,8'h00,8'h00,8'hFF,1'b0,4'd0,4'd7},  // R7 read of deselect page
        '{3'd4,1'b1,8'h00,8'h00,8'h00,1'b1,4'd0,4'd3}   // R3
    };

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        int wd = 0;
        forever begin
            @(posedge clk);
            wd++;
            if (wd > 150000) begin
                n_chk++; n_bad++;
                $display("FAIL watchdog: actual expired expected finished");
                finish_run();
            end
        end
    end

    initial begin
        logic [7:0] rd;
        int cyc, p0;
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1", spi_cs_n, 1, "cs_n in reset");
        check("R1", spi_sck, 0, "sck in reset");
        check("R1", host_ready, 0, "ready in reset");
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        for (int i = 0; i < NV; i++) begin
            string tag;
            tag = $sformatf("R%0d", VECS[i].req);
            slave_byte = VECS[i].miso;
            p0 = pulses;
            access(VECS[i].ofs, VECS[i].wr, VECS[i].wdata, rd, cyc);
            if (!VECS[i].wr) check(tag, rd, VECS[i].exp_rd, $sformatf("rdata v%0d", i));
            check(tag, spi_cs_n, VECS[i].exp_cs, $sformatf("cs_n v%0d", i));
            check(tag, pulses - p0, VECS[i].npul, $sformatf("sck pulses v%0d", i));
            check("R6", cyc, (VECS[i].npul != 0) ? XFER_LAT : 1, $sformatf("latency v%0d", i));
            if (VECS[i].npul != 0)
                check(tag, mosi_cap, VECS[i].wr ? VECS[i].wdata : 8'h00,
                      $sformatf("mosi byte v%0d", i));
        end

        // R1: reset taken mid-byte
        access(3'd1, 1'b1, 8'hFD, rd, cyc);
        @(negedge clk);
        host_req = 1'b1; host_wr = 1'b1; host_ofs = 3'd4; host_wdata = 8'hF0;
        repeat (9) @(negedge clk);
        check("R1", spi_cs_n, 0, "cs_n low during byte");
        rst_n = 1'b0;
        host_req = 1'b0;
        @(negedge clk);
        check("R1", spi_cs_n, 1, "cs_n after mid-byte reset");
        check("R1", spi_sck, 0, "sck after mid-byte reset");
        check("R1", host_ready, 0, "ready after mid-byte reset");
        rst_n = 1'b1;
        @(negedge clk);
        access(3'd1, 1'b0, 8'h00, rd, cyc);
        check("R1", rd, 8'h00, "address byte cleared by reset");
        check("R6", cyc, 1, "register access latency");

        finish_run();
    end
endmodule